// File: doc/BRIEF.md
# Transmit Descriptor Engine

The engine walks a ring of transmit descriptors kept in an internal descriptor store and turns each described buffer into a byte stream for a MAC. A descriptor names a buffer by a byte-granular start address and a byte count. It also carries a ready-to-send flag, an end-of-frame flag and a completion-interrupt enable. Descriptors whose end-of-frame flag is clear are joined with the following ones into one frame. Buffer bytes are fetched one at a time through a request/grant/response port, so any start alignment works.

When a buffer has been emptied, its descriptor is written back with the ready flag cleared. For the descriptor that ends a frame, the write-back waits for the MAC's end-of-frame report. It then stores the MAC status and the total frame length, with the CRC bytes added when CRC append is on, or zero when the MAC reports an aborted oversize frame. A descriptor found without its ready flag stops the engine. The engine raises an idle flag when this happens between frames and a not-ready flag when it happens inside a frame. It then waits for a rising edge on the clear input and resumes at the descriptor where it stopped.

Software loads and inspects descriptors through a host port. Interrupt flags are sticky and are cleared by a write-one mask.

Top module: `txd_engine`

## Requirements
- R1: A descriptor is a 62-bit word: bits [31:0] buffer start address, [42:32] length (11 bits), [58:43] status (16 bits), bit 59 completion-interrupt enable, bit 60 end-of-frame, bit 61 ready. A host write stores the word at `hst_addr`, and `hst_rdata` shows the word at `hst_addr` one clock later.
- R2: After reset, `irq_stat` is 0, no memory request or stream byte is issued, and the engine stays halted even if descriptor 0 is ready. The first rising edge of `tx_clr` starts fetching at descriptor 0.
- R3: The bytes of a buffer are read from start address plus 0, 1, … up to length−1, at any byte alignment, and are sent in that order on `tx_data`. `mem_req`/`mem_addr` are held until `mem_gnt`, and `tx_valid`/`tx_data`/`tx_last` are held until `tx_ready`.
- R4: Descriptors with end-of-frame 0 continue the same frame. `tx_last` is 1 only on the final byte of a descriptor whose end-of-frame bit is 1.
- R5: A buffer emptied in a descriptor with end-of-frame 0 is written back with ready = 0 and all other fields unchanged.
- R6: A frame's last descriptor is written back after `mac_done`. Ready becomes 0, status becomes `mac_stat`, and length becomes the frame's total byte count (low 11 bits), plus 4 when `cfg_crc_en` is 1.
- R7: When `mac_jabort` accompanies `mac_done`, the written-back length is 0 and the completion flag is not raised for that descriptor.
- R8: `irq_stat[0]` (buffer complete) is set when a descriptor with its interrupt enable set is closed normally.
- R9: A descriptor read with ready = 0 at the start of a frame sets `irq_stat[1]` (idle) and halts the engine without touching the stream.
- R10: A descriptor read with ready = 0 inside a frame sets `irq_stat[2]` (not ready), does not set idle, and halts the engine.
- R11: While halted, a constant high `tx_clr` has no effect. Only a 0→1 edge resumes, at the descriptor that stopped the engine, starting a new frame.
- R12: The descriptor index wraps from `RING_DEPTH`−1 to 0, also inside a chained frame.
- R13: `irq_stat` bits stay set until a 1 is written to the matching `irq_clr` bit. A set event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_we | input | 1 | Host descriptor write enable |
| hst_addr | input | $clog2(RING_DEPTH) | Host descriptor index |
| hst_wdata | input | 62 | Host descriptor write word |
| hst_rdata | output | 62 | Descriptor word at hst_addr, one clock later |
| tx_clr | input | 1 | Restart control, acts on rising edge |
| cfg_crc_en | input | 1 | Add 4 CRC bytes to written-back length |
| irq_clr | input | 3 | Write-one clear mask for irq_stat |
| irq_stat | output | 3 | Sticky flags: 0 complete, 1 idle, 2 not ready |
| mem_req | output | 1 | Buffer byte read request |
| mem_addr | output | 32 | Byte address of request |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | MAC accepts byte |
| mac_done | input | 1 | MAC end-of-frame report |
| mac_stat | input | 16 | MAC transmit status |
| mac_jabort | input | 1 | Oversize frame was aborted |

## Verification
The assertions watch the cycle-level rules on every clock. They check that the memory request and stream byte are held through back-pressure, that flags are sticky and that a set beats a clear, that every halt event really halts, that leaving the halt needs a clear edge, and that each write-back steps the ring index by one with wrap. The content of the written-back descriptors can only be shown by the bench's scenarios: frame length with and without CRC, the zero length on abort, and the released flags. The same holds for byte order across unaligned and chained buffers, the choice between idle and not-ready, and resuming at the stopping index.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int unsigned PTR_W  = 32;
   localparam int unsigned LEN_W  = 11;
   localparam int unsigned STAT_W = 16;
   localparam int unsigned BYTE_W = 8;

   typedef struct packed {
      logic              full;
      logic              last;
      logic              ien;
      logic [STAT_W-1:0] stat;
      logic [LEN_W-1:0]  len;
      logic [PTR_W-1:0]  ptr;
   } txd_desc_t;

   localparam int unsigned DESC_W = $bits(txd_desc_t);

   localparam int unsigned IRQ_BUFC  = 0;
   localparam int unsigned IRQ_IDLE  = 1;
   localparam int unsigned IRQ_BUFNR = 2;
   localparam int unsigned IRQ_N     = 3;

   typedef enum logic [2:0] {
      ST_HALT, ST_FETCH, ST_CHECK, ST_MOVE, ST_CLOSE, ST_WSTAT
   } txd_state_e;

   typedef enum logic [1:0] {
      MV_IDLE, MV_REQ, MV_WAIT, MV_SEND
   } txd_mv_e;
endpackage

// File: rtl/txd_desc_ram.sv
module txd_desc_ram #(
   parameter int unsigned DEPTH       = 64,
   parameter int unsigned WIDTH       = 62,
   parameter bit          HOST_RD_REG = 1'b1,
   localparam int unsigned AW         = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             h_we,
   input  logic [AW-1:0]    h_addr,
   input  logic [WIDTH-1:0] h_wdata,
   output logic [WIDTH-1:0] h_rdata,
   input  logic             e_re,
   input  logic             e_we,
   input  logic [AW-1:0]    e_addr,
   input  logic [WIDTH-1:0] e_wdata,
   output logic [WIDTH-1:0] e_rdata
);
   if (DEPTH < 2) begin : g_depth_chk
      $error("txd_desc_ram: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   // host write wins only when both sides hit the same entry
   always_ff @(posedge clk) begin
      if (e_we && !(h_we && h_addr == e_addr)) mem[e_addr] <= e_wdata;
      if (h_we) mem[h_addr] <= h_wdata;
   end

   always_ff @(posedge clk) begin
      if (e_re) e_rdata <= mem[e_addr];
   end

   if (HOST_RD_REG) begin : g_hrd_reg
      always_ff @(posedge clk) h_rdata <= mem[h_addr];
   end else begin : g_hrd_comb
      assign h_rdata = mem[h_addr];
   end
endmodule

// File: rtl/txd_irq_flags.sv
module txd_irq_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        stat_o[i] <= 1'b0;
         else if (set_i[i]) stat_o[i] <= 1'b1;
         else if (clr_i[i]) stat_o[i] <= 1'b0;
      end

      a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_o[i] && !clr_i[i]) |=> stat_o[i]);
      a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> stat_o[i]);
   end
endmodule

// File: rtl/txd_byte_mover.sv
module txd_byte_mover
   import txd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              last_i,
   output logic              done_o,
   output logic              mem_req_o,
   output logic [PTR_W-1:0]  mem_addr_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [BYTE_W-1:0] mem_rdata_i,
   output logic              tx_valid_o,
   output logic [BYTE_W-1:0] tx_data_o,
   output logic              tx_last_o,
   input  logic              tx_ready_i
);
   txd_mv_e           mst_q;
   logic [PTR_W-1:0]  addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic              last_q;
   logic [BYTE_W-1:0] byte_q;
   logic              final_byte;

   assign final_byte = (rem_q == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mst_q  <= MV_IDLE;
         addr_q <= '0;
         rem_q  <= '0;
         last_q <= 1'b0;
         byte_q <= '0;
      end else begin
         unique case (mst_q)
            MV_IDLE: if (go_i) begin
               addr_q <= ptr_i;
               rem_q  <= len_i;
               last_q <= last_i;
               mst_q  <= MV_REQ;
            end
            MV_REQ: if (mem_gnt_i) mst_q <= MV_WAIT;
            MV_WAIT: if (mem_rvalid_i) begin
               byte_q <= mem_rdata_i;
               mst_q  <= MV_SEND;
            end
            MV_SEND: if (tx_ready_i) begin
               addr_q <= addr_q + 1'b1;
               rem_q  <= rem_q - 1'b1;
               mst_q  <= final_byte ? MV_IDLE : MV_REQ;
            end
            default: mst_q <= MV_IDLE;
         endcase
      end
   end

   assign mem_req_o  = (mst_q == MV_REQ);
   assign mem_addr_o = addr_q;
   assign tx_valid_o = (mst_q == MV_SEND);
   assign tx_data_o  = byte_q;
   assign tx_last_o  = last_q && final_byte;
   assign done_o     = (mst_q == MV_SEND) && tx_ready_i && final_byte;

   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
   a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=>
         (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));
   a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (len_i != '0));
endmodule

// File: rtl/txd_ring_fsm.sv
module txd_ring_fsm
   import txd_pkg::*;
#(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned CRC_BYTES = 4,
   localparam int unsigned AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              crc_en_i,
   output logic              e_re_o,
   output logic              e_we_o,
   output logic [AW-1:0]     e_addr_o,
   output txd_desc_t         e_wdata_o,
   input  txd_desc_t         e_rdata_i,
   output logic              go_o,
   output logic [PTR_W-1:0]  ptr_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              last_o,
   input  logic              mv_done_i,
   input  logic              mac_done_i,
   input  logic [STAT_W-1:0] mac_stat_i,
   input  logic              mac_jabort_i,
   output logic [IRQ_N-1:0]  irq_set_o
);
   txd_state_e       state_q, state_d;
   logic [AW-1:0]    idx_q, idx_nx;
   logic             in_frame_q;
   logic [LEN_W-1:0] flen_q;
   txd_desc_t        d_q;
   logic             clr_q;
   logic             clr_rise;

   assign clr_rise = clr_i && !clr_q;
   assign idx_nx   = (idx_q == AW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
   assign e_addr_o = idx_q;
   assign ptr_o    = e_rdata_i.ptr;
   assign len_o    = e_rdata_i.len;
   assign last_o   = e_rdata_i.last;

   always_comb begin
      state_d   = state_q;
      e_re_o    = 1'b0;
      e_we_o    = 1'b0;
      e_wdata_o = d_q;
      go_o      = 1'b0;
      irq_set_o = '0;
      unique case (state_q)
         ST_HALT:  if (clr_rise) state_d = ST_FETCH;
         ST_FETCH: begin
            e_re_o  = 1'b1;
            state_d = ST_CHECK;
         end
         ST_CHECK: begin
            if (!e_rdata_i.full) begin
               if (in_frame_q) irq_set_o[IRQ_BUFNR] = 1'b1;
               else            irq_set_o[IRQ_IDLE]  = 1'b1;
               state_d = ST_HALT;
            end else begin
               go_o    = 1'b1;
               state_d = ST_MOVE;
            end
         end
         ST_MOVE: if (mv_done_i) state_d = d_q.last ? ST_WSTAT : ST_CLOSE;
         ST_CLOSE: begin
            e_we_o              = 1'b1;
            e_wdata_o.full      = 1'b0;
            irq_set_o[IRQ_BUFC] = d_q.ien;
            state_d             = ST_FETCH;
         end
         ST_WSTAT: if (mac_done_i) begin
            e_we_o              = 1'b1;
            e_wdata_o.full      = 1'b0;
            e_wdata_o.stat      = mac_stat_i;
            e_wdata_o.len       = mac_jabort_i ? '0 :
                                  flen_q + (crc_en_i ? LEN_W'(CRC_BYTES) : '0);
            irq_set_o[IRQ_BUFC] = d_q.ien && !mac_jabort_i;
            state_d             = ST_FETCH;
         end
         default: state_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_HALT;
         idx_q      <= '0;
         in_frame_q <= 1'b0;
         flen_q     <= '0;
         d_q        <= '0;
         clr_q      <= 1'b0;
      end else begin
         state_q <= state_d;
         clr_q   <= clr_i;
         if (state_q == ST_HALT && clr_rise) begin
            in_frame_q <= 1'b0;
            flen_q     <= '0;
         end
         if (state_q == ST_CHECK && e_rdata_i.full) begin
            d_q        <= e_rdata_i;
            in_frame_q <= 1'b1;
         end
         if (state_q == ST_MOVE && mv_done_i) flen_q <= flen_q + d_q.len;
         if (e_we_o) idx_q <= idx_nx;
         if (state_q == ST_WSTAT && mac_done_i) begin
            in_frame_q <= 1'b0;
            flen_q     <= '0;
         end
      end
   end

   a_r9_r10_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_set_o[IRQ_IDLE] || irq_set_o[IRQ_BUFNR]) |=> (state_q == ST_HALT));
   a_r11_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |=> ((state_q == ST_HALT) || $past(clr_i && !clr_q)));
   a_r12_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
      e_we_o |=> (((idx_q == $past(idx_q) + 1'b1) && ($past(idx_q) != AW'(DEPTH - 1)))
                  || ((idx_q == '0) && ($past(idx_q) == AW'(DEPTH - 1)))));
endmodule

// File: rtl/txd_engine.sv
module txd_engine
   import txd_pkg::*;
#(
   parameter int unsigned RING_DEPTH  = 64,
   parameter int unsigned CRC_BYTES   = 4,
   parameter bit          HOST_RD_REG = 1'b1,
   localparam int unsigned AW         = $clog2(RING_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [AW-1:0]     hst_addr,
   input  logic [DESC_W-1:0] hst_wdata,
   output logic [DESC_W-1:0] hst_rdata,
   input  logic              tx_clr,
   input  logic              cfg_crc_en,
   input  logic [IRQ_N-1:0]  irq_clr,
   output logic [IRQ_N-1:0]  irq_stat,
   output logic              mem_req,
   output logic [PTR_W-1:0]  mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   input  logic              mac_done,
   input  logic [STAT_W-1:0] mac_stat,
   input  logic              mac_jabort
);
   if (RING_DEPTH < 2) begin : g_ring_chk
      $error("txd_engine: RING_DEPTH must be at least 2");
   end
   if (CRC_BYTES > 8) begin : g_crc_chk
      $error("txd_engine: CRC_BYTES out of range");
   end

   logic             e_re, e_we;
   logic [AW-1:0]    e_addr;
   txd_desc_t        e_wdata, e_rdata;
   logic             go, mv_done, mv_last;
   logic [PTR_W-1:0] mv_ptr;
   logic [LEN_W-1:0] mv_len;
   logic [IRQ_N-1:0] irq_set;

   txd_desc_ram #(
      .DEPTH(RING_DEPTH), .WIDTH(DESC_W), .HOST_RD_REG(HOST_RD_REG)
   ) u_ram (
      .clk(clk), .h_we(hst_we), .h_addr(hst_addr), .h_wdata(hst_wdata),
      .h_rdata(hst_rdata), .e_re(e_re), .e_we(e_we), .e_addr(e_addr),
      .e_wdata(e_wdata), .e_rdata(e_rdata)
   );

   txd_ring_fsm #(.DEPTH(RING_DEPTH), .CRC_BYTES(CRC_BYTES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .clr_i(tx_clr), .crc_en_i(cfg_crc_en),
      .e_re_o(e_re), .e_we_o(e_we), .e_addr_o(e_addr), .e_wdata_o(e_wdata),
      .e_rdata_i(e_rdata), .go_o(go), .ptr_o(mv_ptr), .len_o(mv_len),
      .last_o(mv_last), .mv_done_i(mv_done), .mac_done_i(mac_done),
      .mac_stat_i(mac_stat), .mac_jabort_i(mac_jabort), .irq_set_o(irq_set)
   );

   txd_byte_mover u_mover (
      .clk(clk), .rst_n(rst_n), .go_i(go), .ptr_i(mv_ptr), .len_i(mv_len),
      .last_i(mv_last), .done_o(mv_done), .mem_req_o(mem_req),
      .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
      .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
      .tx_last_o(tx_last), .tx_ready_i(tx_ready)
   );

   txd_irq_flags #(.N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr),
      .stat_o(irq_stat)
   );
endmodule

// File: tb/sim_txd_engine.sv
`timescale 1ns/1ps
module sim_txd_engine;
   localparam int RING = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_we = 1'b0;
   logic [2:0]  hst_addr = '0;
   logic [61:0] hst_wdata = '0;
   logic [61:0] hst_rdata;
   logic        tx_clr = 1'b0;
   logic        cfg_crc_en = 1'b0;
   logic [2:0]  irq_clr = '0;
   logic [2:0]  irq_stat;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_last;
   logic        tx_ready = 1'b0;
   logic        mac_done = 1'b0;
   logic [15:0] mac_stat = '0;
   logic        mac_jabort = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [8:0]  expq[$];
   logic [15:0] next_stat = '0;
   logic        next_abort = 1'b0;

   always #2.5 clk = ~clk;

   txd_engine #(.RING_DEPTH(RING)) u0 (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .tx_clr(tx_clr),
      .cfg_crc_en(cfg_crc_en), .irq_clr(irq_clr), .irq_stat(irq_stat),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
      .mac_done(mac_done), .mac_stat(mac_stat), .mac_jabort(mac_jabort)
   );

   function automatic logic [61:0] mk(logic full, logic last, logic ien,
                                      logic [15:0] st, logic [10:0] len,
                                      logic [31:0] ptr);
      return {full, last, ien, st, len, ptr};
   endfunction

   function automatic logic [7:0] byte_at(logic [31:0] a);
      return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
   endfunction

   task automatic chk(bit ok, string req, string what,
                      logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic push_buf(logic [31:0] ptr, int len, bit eof);
      for (int i = 0; i < len; i++)
         expq.push_back({eof && (i == len - 1), byte_at(ptr + 32'(i))});
   endtask

   task automatic hwrite(int idx, logic [61:0] w);
      @(posedge clk); #1;
      hst_we = 1'b1; hst_addr = 3'(idx); hst_wdata = w;
      @(posedge clk); #1;
      hst_we = 1'b0;
   endtask

   task automatic check_desc(int idx, logic [61:0] exp, string req);
      @(posedge clk); #1;
      hst_addr = 3'(idx);
      @(posedge clk);
      @(negedge clk);
      chk(hst_rdata == exp, req, $sformatf("desc%0d", idx),
          64'(hst_rdata), 64'(exp));
   endtask

   task automatic clr_edge();
      @(posedge clk); #1 tx_clr = 1'b0;
      @(posedge clk); #1 tx_clr = 1'b1;
   endtask

   task automatic irq_wipe(logic [2:0] m);
      @(posedge clk); #1 irq_clr = m;
      @(posedge clk); #1 irq_clr = '0;
   endtask

   task automatic wait_flag(int b, string req);
      bit seen = 1'b0;
      for (int k = 0; k < 20000 && !seen; k++) begin
         @(negedge clk);
         if (irq_stat[b]) seen = 1'b1;
      end
      chk(seen, req, "flag reached", 64'(seen), 64'd1);
      repeat (3) @(negedge clk);
      chk(expq.size() == 0, req, "all bytes sent", 64'(expq.size()), 64'd0);
   endtask

   // memory model: grant pattern with gaps, data one cycle after accept
   initial begin
      int gc = 0;
      bit pend = 1'b0;
      logic [31:0] pa = '0;
      forever begin
         @(posedge clk); #1;
         mem_rvalid = 1'b0;
         if (pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = byte_at(pa);
            pend = 1'b0;
         end
         mem_gnt = (gc % 3) != 1;
         gc++;
         @(negedge clk);
         if (mem_req && mem_gnt) begin
            pa = mem_addr;
            pend = 1'b1;
         end
      end
   end

   // stream back-pressure
   initial begin
      int rc = 0;
      forever begin
         @(posedge clk); #1;
         tx_ready = (rc % 4) != 2;
         rc++;
      end
   end

   // MAC end-of-frame reporter
   initial begin
      forever begin
         @(negedge clk);
         if (tx_valid && tx_ready && tx_last) begin
            repeat (3) @(posedge clk);
            #1;
            mac_done = 1'b1; mac_stat = next_stat; mac_jabort = next_abort;
            @(posedge clk); #1;
            mac_done = 1'b0; mac_jabort = 1'b0;
         end
      end
   end

   // scoreboard monitor (R3 order/data, R4 last marker)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R3", "unexpected byte", 64'(tx_data), 64'd0);
            end else begin
               logic [8:0] e;
               e = expq.pop_front();
               chk(tx_data == e[7:0], "R3", "byte", 64'(tx_data), 64'(e[7:0]));
               chk(tx_last == e[8], "R4", "last marker", 64'(tx_last), 64'(e[8]));
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog", "run time", 64'd1, 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk(irq_stat == 3'b000, "R2", "irq after reset", 64'(irq_stat), 64'd0);
      chk(!tx_valid, "R2", "tx_valid after reset", 64'(tx_valid), 64'd0);
      chk(!mem_req, "R2", "mem_req after reset", 64'(mem_req), 64'd0);

      for (int i = 0; i < RING; i++) hwrite(i, '0);
      // R1 host path
      hwrite(7, mk(1'b0, 1'b1, 1'b0, 16'hA5C3, 11'h5AA, 32'hCAFE_F00D));
      check_desc(7, mk(1'b0, 1'b1, 1'b0, 16'hA5C3, 11'h5AA, 32'hCAFE_F00D), "R1");

      // scenario 1: two-descriptor frame, unaligned buffers
      hwrite(0, mk(1'b1, 1'b0, 1'b1, 16'h0, 11'd20, 32'h103));
      hwrite(1, mk(1'b1, 1'b1, 1'b0, 16'h0, 11'd16, 32'h2F1));
      hwrite(2, mk(1'b0, 1'b1, 1'b1, 16'h0, 11'd40, 32'h400));
      repeat (20) @(negedge clk);
      chk(irq_stat == 3'b000, "R2", "no start without clear edge", 64'(irq_stat), 64'd0);
      push_buf(32'h103, 20, 1'b0);
      push_buf(32'h2F1, 16, 1'b1);
      next_stat = 16'hBEEF;
      clr_edge();
      wait_flag(1, "R9");
      chk(irq_stat == 3'b011, "R8", "complete+idle", 64'(irq_stat), 64'd3);
      check_desc(0, mk(1'b0, 1'b0, 1'b1, 16'h0, 11'd20, 32'h103), "R5");
      check_desc(1, mk(1'b0, 1'b1, 1'b0, 16'hBEEF, 11'd36, 32'h2F1), "R6");
      irq_wipe(3'b001);
      @(negedge clk);
      chk(irq_stat == 3'b010, "R13", "w1c one bit", 64'(irq_stat), 64'd2);

      // scenario 2: level-high clear does nothing; resume at index 2 with CRC
      irq_wipe(3'b111);
      hwrite(2, mk(1'b1, 1'b1, 1'b1, 16'h0, 11'd40, 32'h400));
      hwrite(3, mk(1'b0, 1'b0, 1'b0, 16'h0, 11'd34, 32'h55D));
      repeat (30) @(negedge clk);
      chk(irq_stat == 3'b000, "R11", "high level ignored", 64'(irq_stat), 64'd0);
      check_desc(2, mk(1'b1, 1'b1, 1'b1, 16'h0, 11'd40, 32'h400), "R11");
      push_buf(32'h400, 40, 1'b1);
      next_stat = 16'h1234;
      cfg_crc_en = 1'b1;
      clr_edge();
      wait_flag(1, "R11");
      check_desc(2, mk(1'b0, 1'b1, 1'b1, 16'h1234, 11'd44, 32'h400), "R6");
      chk(irq_stat == 3'b011, "R8", "complete on last", 64'(irq_stat), 64'd3);

      // scenario 3: not-ready inside a frame
      irq_wipe(3'b111);
      cfg_crc_en = 1'b0;
      hwrite(3, mk(1'b1, 1'b0, 1'b0, 16'h0, 11'd34, 32'h55D));
      hwrite(4, mk(1'b0, 1'b1, 1'b1, 16'h0, 11'd35, 32'h600));
      push_buf(32'h55D, 34, 1'b0);
      clr_edge();
      wait_flag(2, "R10");
      chk(irq_stat == 3'b100, "R10", "not-ready only", 64'(irq_stat), 64'd4);
      check_desc(3, mk(1'b0, 1'b0, 1'b0, 16'h0, 11'd34, 32'h55D), "R5");
      check_desc(4, mk(1'b0, 1'b1, 1'b1, 16'h0, 11'd35, 32'h600), "R10");

      // scenario 4: aborted oversize frame
      irq_wipe(3'b111);
      hwrite(4, mk(1'b1, 1'b1, 1'b1, 16'h0, 11'd35, 32'h600));
      hwrite(5, mk(1'b0, 1'b0, 1'b0, 16'h0, 11'd10, 32'h7FD));
      push_buf(32'h600, 35, 1'b1);
      next_stat = 16'hDEAD;
      next_abort = 1'b1;
      clr_edge();
      wait_flag(1, "R7");
      check_desc(4, mk(1'b0, 1'b1, 1'b1, 16'hDEAD, 11'd0, 32'h600), "R7");
      chk(irq_stat == 3'b010, "R7", "no complete on abort", 64'(irq_stat), 64'd2);

      // scenario 5: chained frame across the ring wrap
      irq_wipe(3'b111);
      next_abort = 1'b0;
      next_stat = 16'h0F0F;
      hwrite(5, mk(1'b1, 1'b0, 1'b0, 16'h0, 11'd10, 32'h7FD));
      hwrite(6, mk(1'b1, 1'b0, 1'b1, 16'h0, 11'd12, 32'h80A));
      hwrite(7, mk(1'b1, 1'b0, 1'b0, 16'h0, 11'd8,  32'h003));
      hwrite(0, mk(1'b1, 1'b1, 1'b0, 16'h0, 11'd14, 32'h9FF));
      hwrite(1, mk(1'b0, 1'b0, 1'b0, 16'h0, 11'd14, 32'h0));
      push_buf(32'h7FD, 10, 1'b0);
      push_buf(32'h80A, 12, 1'b0);
      push_buf(32'h003, 8, 1'b0);
      push_buf(32'h9FF, 14, 1'b1);
      clr_edge();
      wait_flag(1, "R12");
      check_desc(7, mk(1'b0, 1'b0, 1'b0, 16'h0, 11'd8, 32'h003), "R12");
      check_desc(0, mk(1'b0, 1'b1, 1'b0, 16'h0F0F, 11'd44, 32'h9FF), "R12");
      chk(irq_stat == 3'b011, "R4", "chain complete+idle", 64'(irq_stat), 64'd3);

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule